// File: doc/BRIEF.md
# 64-bit Alarm Timer with Prescaler

This block is a general-purpose 64-bit time base. A programmable prescaler divides the system clock into ticks. On each tick, while the timer runs, the counter moves one step up or down. After each tick the new count is compared with a 64-bit alarm value. On a match the block raises an alarm. It can then reload the counter from a 64-bit load value, and it disarms itself.

Software drives the block through a simple write port. The port holds one configuration word, the alarm and load values written as two 32-bit halves each, and two strobe addresses. The snapshot strobe copies the live count into two stable read words. The load strobe forces the load value into the counter at once, whether or not auto-reload is enabled. An alarm can raise a level interrupt, which is held until it is cleared, a one-cycle edge interrupt, or both.

Top module: `alarm_timer64`

## Requirements
- R1: After reset both interrupt outputs are 0 and the snapshot words read 0. The configuration word resets with the prescale field at 1, direction up, auto-reload on, and run, arm and both interrupt enables off. The write addresses are: 0 configuration, 1 alarm low, 2 alarm high, 3 load low, 4 load high, 5 snapshot strobe, 6 load strobe.
- R2: The prescale field sits in configuration bits [31:16]. The counter advances once every D clocks, where D equals the field value, except that a field of 0 gives D=65536 and a field of 1 gives D=2.
- R3: Configuration bit 1 sets the direction: 1 counts up and 0 counts down. The count wraps modulo 2^64, and carries pass between the two 32-bit halves.
- R4: Configuration bit 0 (run) gates counting. While it is 0, the count holds its value.
- R5: An alarm fires when configuration bit 3 (arm) is set and the count produced by a tick equals the full 64-bit alarm value. A difference in the high word alone prevents a match.
- R6: Hardware clears the arm bit in the same clock edge that signals the alarm, so a later match does not fire again until software re-arms.
- R7: With configuration bit 2 (auto-reload) set, an alarm loads the counter with the 64-bit load value. With bit 2 clear, counting continues past the alarm value.
- R8: A write of any data to the snapshot address copies the current count into the low and high snapshot outputs. The snapshot stays unchanged until the next such write.
- R9: A write of any data to the load address replaces the count with the load value at that clock edge. A tick in the same cycle, including an alarm reload, does not override it.
- R10: With configuration bit 4 set, an alarm sets the level interrupt. It stays high until the irq_clr input is pulsed. With bit 4 clear, it does not rise.
- R11: With configuration bit 5 set, each alarm gives exactly one single-cycle pulse on the edge interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| irq_clr | input | 1 | Clears the level interrupt |
| snap_lo | output | 32 | Snapshot of count bits [31:0] |
| snap_hi | output | 32 | Snapshot of count bits [63:32] |
| irq_level | output | 1 | Held alarm interrupt |
| irq_edge | output | 1 | One-cycle alarm pulse |

## Verification
The counting path is driven from a table of cases that vary the prescale field (0, 1, 2, 3, 4, 5), the direction, and the start value. Setting the prescale field to 1 or to 2 separates the "1 means 2" rule from plain division. The 0 case proves the 65536 divisor. A start value just below a 32-bit boundary shows carry into the high word, and a down count from 3 shows the 64-bit wrap. In the alarm tests the final count tells apart a missing reload, a missing self-clear (the count would keep cycling) and a wrong high-word compare. Counting edge pulses and watching the level line before and after irq_clr separates the two interrupt enables.

// File: rtl/alarm_timer64_pkg.sv
package alarm_timer64_pkg;

    parameter int PSC_W   = 16;
    parameter int PSC_LSB = 16;
    parameter int ADR_W   = 3;

    localparam logic [ADR_W-1:0] ADR_CFG  = 3'd0;
    localparam logic [ADR_W-1:0] ADR_ALO  = 3'd1;
    localparam logic [ADR_W-1:0] ADR_AHI  = 3'd2;
    localparam logic [ADR_W-1:0] ADR_LLO  = 3'd3;
    localparam logic [ADR_W-1:0] ADR_LHI  = 3'd4;
    localparam logic [ADR_W-1:0] ADR_SNAP = 3'd5;
    localparam logic [ADR_W-1:0] ADR_LOAD = 3'd6;

    typedef struct packed {
        logic [PSC_W-1:0] presc;
        logic             edge_en;
        logic             lvl_en;
        logic             arm;
        logic             auto_rld;
        logic             count_up;
        logic             run;
    } tmr_cfg_t;

    localparam tmr_cfg_t CFG_RST = '{
        presc:    PSC_W'(1),
        edge_en:  1'b0,
        lvl_en:   1'b0,
        arm:      1'b0,
        auto_rld: 1'b1,
        count_up: 1'b1,
        run:      1'b0
    };

endpackage

// File: rtl/alarm_timer64_regs.sv
module alarm_timer64_regs
    import alarm_timer64_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alarm_hit,
    output tmr_cfg_t          cfg,
    output logic [CNT_W-1:0]  alarm_val,
    output logic [CNT_W-1:0]  load_val,
    output logic              snap_stb,
    output logic              load_stb
);

    typedef struct packed {
        tmr_cfg_t         cfg;
        logic [CNT_W-1:0] alarm;
        logic [CNT_W-1:0] load;
    } reg_st_t;

    reg_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        snap_stb = 1'b0;
        load_stb = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADR_CFG: begin
                    s_d.cfg.run      = wr_data[0];
                    s_d.cfg.count_up = wr_data[1];
                    s_d.cfg.auto_rld = wr_data[2];
                    s_d.cfg.arm      = wr_data[3];
                    s_d.cfg.lvl_en   = wr_data[4];
                    s_d.cfg.edge_en  = wr_data[5];
                    s_d.cfg.presc    = wr_data[PSC_LSB +: PSC_W];
                end
                ADR_ALO:  s_d.alarm[DATA_W-1:0]     = wr_data;
                ADR_AHI:  s_d.alarm[CNT_W-1:DATA_W] = wr_data;
                ADR_LLO:  s_d.load[DATA_W-1:0]      = wr_data;
                ADR_LHI:  s_d.load[CNT_W-1:DATA_W]  = wr_data;
                ADR_SNAP: snap_stb = 1'b1;
                ADR_LOAD: load_stb = 1'b1;
                default: ;
            endcase
        end
        // the hardware disarm overrides a concurrent software write
        if (alarm_hit) s_d.cfg.arm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg   <= CFG_RST;
            s_q.alarm <= '0;
            s_q.load  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg       = s_q.cfg;
    assign alarm_val = s_q.alarm;
    assign load_val  = s_q.load;

    // R6
    arm_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> !cfg.arm);

endmodule

// File: rtl/alarm_timer64_presc.sv
module alarm_timer64_presc
    import alarm_timer64_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] presc,
    output logic             tick
);

    localparam logic [PSC_W-1:0] P_ONE = PSC_W'(1);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_st_t;

    psc_st_t s_d, s_q;
    logic [PSC_W-1:0] lim;

    always_comb begin
        // terminal value is divisor minus one
        if (presc == '0)        lim = '1;
        else if (presc == P_ONE) lim = P_ONE;
        else                     lim = presc - P_ONE;

        // >= lets a shrinking divisor take effect at once
        tick  = run && (s_q.cnt >= lim);
        s_d   = s_q;
        if (!run || tick) s_d.cnt = '0;
        else              s_d.cnt = s_q.cnt + P_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    // R2
    no_back_to_back_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/alarm_timer64_core.sv
module alarm_timer64_core
    import alarm_timer64_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_cfg_t         cfg,
    input  logic [CNT_W-1:0] alarm_val,
    input  logic [CNT_W-1:0] load_val,
    input  logic             snap_stb,
    input  logic             load_stb,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] snap,
    output logic             irq_level,
    output logic             irq_edge,
    output logic             alarm_hit
);

    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             lvl;
        logic             edg;
    } core_st_t;

    core_st_t s_d, s_q;
    logic [CNT_W-1:0] stepped;

    always_comb begin
        stepped   = cfg.count_up ? (s_q.cnt + C_ONE) : (s_q.cnt - C_ONE);
        alarm_hit = tick && cfg.arm && (stepped == alarm_val);

        s_d = s_q;
        if (load_stb)
            s_d.cnt = load_val;
        else if (tick)
            s_d.cnt = (alarm_hit && cfg.auto_rld) ? load_val : stepped;

        if (snap_stb) s_d.snap = s_q.cnt;

        if (alarm_hit && cfg.lvl_en) s_d.lvl = 1'b1;
        else if (irq_clr)            s_d.lvl = 1'b0;

        s_d.edg = alarm_hit && cfg.edge_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign snap      = s_q.snap;
    assign irq_level = s_q.lvl;
    assign irq_edge  = s_q.edg;

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_stb) |=> $stable(s_q.cnt));

    // R9
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (s_q.cnt == $past(load_val)));

    // R8
    snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_stb |=> $stable(snap));

    // R10
    level_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_level) |-> $past(irq_clr));

    // R11
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_edge |=> !irq_edge);

endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
    import alarm_timer64_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] snap_lo,
    output logic [DATA_W-1:0] snap_hi,
    output logic              irq_level,
    output logic              irq_edge
);

    localparam int CNT_W = 2 * DATA_W;

    tmr_cfg_t         cfg;
    logic [CNT_W-1:0] alarm_val;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] snap;
    logic             snap_stb;
    logic             load_stb;
    logic             tick;
    logic             alarm_hit;

    alarm_timer64_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .alarm_hit (alarm_hit),
        .cfg       (cfg),
        .alarm_val (alarm_val),
        .load_val  (load_val),
        .snap_stb  (snap_stb),
        .load_stb  (load_stb)
    );

    alarm_timer64_presc u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg.run),
        .presc (cfg.presc),
        .tick  (tick)
    );

    alarm_timer64_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cfg       (cfg),
        .alarm_val (alarm_val),
        .load_val  (load_val),
        .snap_stb  (snap_stb),
        .load_stb  (load_stb),
        .irq_clr   (irq_clr),
        .snap      (snap),
        .irq_level (irq_level),
        .irq_edge  (irq_edge),
        .alarm_hit (alarm_hit)
    );

    assign snap_lo = snap[DATA_W-1:0];
    assign snap_hi = snap[CNT_W-1:DATA_W];

endmodule

// File: tb/tb_alarm_timer64.sv
module tb_alarm_timer64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        irq_clr = 1'b0;
    logic [31:0] snap_lo, snap_hi;
    logic        irq_level, irq_edge;

    int n_chk = 0;
    int n_err = 0;
    int edge_cnt = 0;

    always #5 clk = ~clk;

    alarm_timer64 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_clr(irq_clr), .snap_lo(snap_lo),
        .snap_hi(snap_hi), .irq_level(irq_level), .irq_edge(irq_edge)
    );

    always @(negedge clk) if (rst_n && irq_edge) edge_cnt++;

    typedef struct packed {
        logic [15:0] presc;
        logic        up;
        logic [63:0] ld;
        logic [31:0] n;
        logic [63:0] expv;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{presc:16'd1, up:1'b1, ld:64'd0,            n:32'd20, expv:64'd10},
        '{presc:16'd2, up:1'b1, ld:64'd0,            n:32'd21, expv:64'd10},
        '{presc:16'd5, up:1'b1, ld:64'd1000,         n:32'd50, expv:64'd1010},
        '{presc:16'd3, up:1'b0, ld:64'd50,           n:32'd30, expv:64'd40},
        '{presc:16'd1, up:1'b0, ld:64'd3,            n:32'd10, expv:64'hFFFF_FFFF_FFFF_FFFE},
        '{presc:16'd1, up:1'b1, ld:64'h0_FFFF_FFFE,  n:32'd8,  expv:64'h1_0000_0002},
        '{presc:16'd4, up:1'b1, ld:64'd7,            n:32'd3,  expv:64'd7}
    };

    function automatic logic [31:0] cfgw(input logic run, input logic up,
                                         input logic rld, input logic arm,
                                         input logic lvl, input logic edg,
                                         input logic [15:0] psc);
        return {psc, 10'd0, edg, lvl, arm, rld, up, run};
    endfunction

    // caller stands at a falling edge; returns at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_load(input logic [63:0] v);
        wr(3'd3, v[31:0]);
        wr(3'd4, v[63:32]);
        wr(3'd6, 32'hDEAD_BEEF);
    endtask

    task automatic set_alarm(input logic [63:0] v);
        wr(3'd1, v[31:0]);
        wr(3'd2, v[63:32]);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] snap64();
        return {snap_hi, snap_lo};
    endfunction

    // run for n clock edges with the given config, then stop and snapshot
    task automatic run_for(input logic [31:0] c, input int n);
        wr(3'd0, c);
        repeat (n - 1) @(negedge clk);
        wr(3'd0, c & ~32'h9);
        wr(3'd5, 32'h0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 level", {63'd0, irq_level}, 64'd0);
        check("R1 edge",  {63'd0, irq_edge},  64'd0);
        check("R1 snap",  snap64(), 64'd0);
        // R4 not running after reset
        repeat (10) @(negedge clk);
        wr(3'd5, 32'h1);
        check("R4 idle count", snap64(), 64'd0);

        // table walk: R2 prescale, R3 direction and wrap
        for (int i = 0; i < NV; i++) begin
            set_load(VEC[i].ld);
            run_for(cfgw(1, VEC[i].up, 0, 0, 0, 0, VEC[i].presc), int'(VEC[i].n));
            check($sformatf("R2/R3 vector %0d", i), snap64(), VEC[i].expv);
        end

        // R4 stopped timer holds
        repeat (20) @(negedge clk);
        wr(3'd5, 32'h0);
        check("R4 hold after stop", snap64(), 64'd7);

        // R2 prescale 0 means 65536
        set_load(64'd0);
        run_for(cfgw(1, 1, 0, 0, 0, 0, 16'd0), 65536 * 2 + 5);
        check("R2 prescale zero", snap64(), 64'd2);

        // R5 R6 R7 R10 R11 alarm with reload; self-clear stops repeat firing
        edge_cnt = 0;
        set_load(64'd100);
        set_alarm(64'd103);
        run_for(cfgw(1, 1, 1, 1, 1, 1, 16'd1), 20);
        check("R6/R7 count after reload", snap64(), 64'd107);
        check("R10 level set", {63'd0, irq_level}, 64'd1);
        check("R11 one edge pulse", 64'(edge_cnt), 64'd1);
        repeat (5) @(negedge clk);
        check("R10 level held", {63'd0, irq_level}, 64'd1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R10 level cleared", {63'd0, irq_level}, 64'd0);

        // R5 high word mismatch prevents match
        edge_cnt = 0;
        set_load(64'd100);
        set_alarm({32'd1, 32'd103});
        run_for(cfgw(1, 1, 1, 1, 1, 1, 16'd1), 20);
        check("R5 high word", snap64(), 64'd110);
        check("R5 no edge", 64'(edge_cnt), 64'd0);
        check("R5 no level", {63'd0, irq_level}, 64'd0);

        // R7 no reload; R10 level disabled; R11 edge enabled
        edge_cnt = 0;
        set_load(64'd100);
        set_alarm(64'd103);
        run_for(cfgw(1, 1, 0, 1, 0, 1, 16'd1), 20);
        check("R7 no reload", snap64(), 64'd110);
        check("R10 level disabled", {63'd0, irq_level}, 64'd0);
        check("R11 edge only", 64'(edge_cnt), 64'd1);

        // R3/R7 alarm while counting down
        set_load(64'd10);
        set_alarm(64'd7);
        run_for(cfgw(1, 0, 1, 1, 0, 0, 16'd1), 20);
        check("R7 down reload", snap64(), 64'd3);

        // R8 snapshot stays while the count moves
        held = snap64();
        wr(3'd0, cfgw(1, 1, 0, 0, 0, 0, 16'd1));
        repeat (12) @(negedge clk);
        check("R8 stable", snap64(), held);
        wr(3'd5, 32'h0);
        n_chk++;
        if (snap64() == held) begin
            n_err++;
            $display("FAIL R8 refresh: actual=%h expected=changed", snap64());
        end

        // R9 load strobe while running takes effect at its edge
        set_load(64'h0000_0005_0000_01F4);
        wr(3'd5, 32'h0);
        check("R9 immediate load", snap64(), 64'h0000_0005_0000_01F4);
        wr(3'd0, cfgw(0, 1, 0, 0, 0, 0, 16'd1));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule